// File: doc/BRIEF.md
# Double-Buffered Converter Code Interface

This block is the digital front end of a 14-bit data converter. It holds two code registers in series. The first is a staging register that software or a host fills. The second is an output register, and only its contents reach the analog core. The staging register loads in one of two ways, chosen by a mode input. In parallel mode it takes a 14-bit bus, qualified by active-low select and write strobes. In serial mode it takes a 16-bit framed bit stream. An active-low load strobe copies the staging register into the output register.

Both registers behave as level-sensitive latches, retimed to the system clock. An interlock keeps them from being open at the same time. While a parallel write holds the staging register open, the output register is frozen, even when the load strobe is low. This allows the load strobe to be tied low. The output then picks up the new code on its own as soon as the write ends.

Codes are 14-bit two's complement, from 0x2000 (most negative) through 0x0000 (mid-scale) to 0x1FFF (most positive). Every input is taken as synchronous to `clk`. The serial clock must stay at each level for at least two system clock cycles.

Top module: `dbl_dac_front`

## Requirements
- R1: After reset, `dac_code` is 0x0000 and `dac_upd` is low.
- R2: In parallel mode (`mode_ser`=0), while `cs_n` and `wr_n` are both low, the staging register follows `par_data` bit 13 (MSB) to bit 0 (LSB). It keeps the last value seen before either strobe rises. The full range 0x2000 to 0x1FFF passes unaltered.
- R3: With `cs_n` or `wr_n` high, `par_data` changes have no effect on the staging register.
- R4: While a parallel write is open (mode 0, `cs_n` and `wr_n` low), `dac_code` does not change, even with `ldac_n` low.
- R5: With `ldac_n` low and no parallel write open, the output register copies the staging register on the next clock. With `ldac_n` high, `dac_code` holds.
- R6: With `ldac_n` held low, `dac_code` takes the written value on the first clock edge that samples the parallel write as closed.
- R7: In serial mode (`mode_ser`=1), a frame starts with `sync_n` low. `sdata` is sampled on each falling edge of `sclk`, MSB first. The frame is 16 bits. The first 2 bits are dropped and the last 14 form the code. The staging register changes only after the 16th bit.
- R8: A frame ended by `sync_n` rising before 16 falling `sclk` edges is discarded. The staging register keeps its value, and the next frame starts from bit 0.
- R9: The serial pins have no effect in parallel mode. The parallel strobes have no effect in serial mode.
- R10: `dac_upd` is high for exactly one cycle, in the same cycle that `dac_code` shows a new value, and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ser | input | 1 | 0 selects the parallel load, 1 selects the serial load |
| cs_n | input | 1 | Active-low select for parallel writes |
| wr_n | input | 1 | Active-low write strobe for parallel writes |
| par_data | input | 14 | Parallel code word |
| sclk | input | 1 | Serial bit clock, sampled by `clk` |
| sync_n | input | 1 | Active-low serial frame marker |
| sdata | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Active-low load strobe for the output register |
| dac_code | output | 14 | Two's complement code to the analog core |
| dac_upd | output | 1 | One-cycle pulse when `dac_code` changes |

## Verification
If the staging register is wrong, nothing shows until a load: the bad code appears on `dac_code` one clock after `ldac_n` low is sampled outside a write. If the interlock is broken, `dac_code` moves while a write is still open, together with a `dac_upd` pulse. This shows up in the middle of a write with `ldac_n` tied low. If the serial bit counter is off by one, or fails to clear after an aborted frame, the wrong code appears, or the update comes one bit early. Both become visible within three clocks of the 16th falling `sclk` edge.

// File: rtl/dbl_dac_pkg.sv
package dbl_dac_pkg;
    typedef enum logic {
        MODE_PAR = 1'b0,
        MODE_SER = 1'b1
    } load_mode_e;
endpackage

// File: rtl/dbl_dac_serial_rx.sv
module dbl_dac_serial_rx #(
    parameter int CODE_W  = 14,
    parameter int FRAME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              sclk,
    input  logic              sync_n,
    input  logic              sdata,
    output logic              frame_done,
    output logic [CODE_W-1:0] frame_code
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

    typedef struct packed {
        logic              sclk_q;
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] shreg;
        logic              done;
    } rx_state_t;

    rx_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.sclk_q = sclk;
        s_d.done   = 1'b0;
        if (!ser_en || sync_n) begin
            s_d.cnt = '0;
        end else if (s_q.sclk_q && !sclk && (s_q.cnt != FULL_CNT)) begin
            // leading bits fall out of the top of the shifter
            s_d.shreg = {s_q.shreg[CODE_W-2:0], sdata};
            s_d.cnt   = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST_BIT) begin
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sclk_q: 1'b1, cnt: '0, shreg: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_done = s_q.done;
    assign frame_code = s_q.shreg;
endmodule

// File: rtl/dbl_dac_stage_reg.sv
module dbl_dac_stage_reg #(
    parameter int CODE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_open,
    input  logic [CODE_W-1:0] par_data,
    input  logic              ser_done,
    input  logic [CODE_W-1:0] ser_code,
    output logic [CODE_W-1:0] stage_code
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (par_open) begin
            st_d.code = par_data;
        end else if (ser_done) begin
            st_d.code = ser_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_code = st_q.code;
endmodule

// File: rtl/dbl_dac_out_reg.sv
module dbl_dac_out_reg #(
    parameter int CODE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ldac_n,
    input  logic              par_open,
    input  logic [CODE_W-1:0] stage_code,
    output logic [CODE_W-1:0] out_code,
    output logic              out_upd
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              upd;
    } out_t;

    out_t o_d, o_q;
    logic follow;

    always_comb begin
        // interlock: never open while the staging register is open
        follow = !ldac_n && !par_open;
        o_d    = o_q;
        if (follow) begin
            o_d.code = stage_code;
        end
        o_d.upd = (o_d.code != o_q.code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_code = o_q.code;
    assign out_upd  = o_q.upd;
endmodule

// File: rtl/dbl_dac_front.sv
module dbl_dac_front #(
    parameter int CODE_W  = 14,
    parameter int FRAME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ser,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [CODE_W-1:0] par_data,
    input  logic              sclk,
    input  logic              sync_n,
    input  logic              sdata,
    input  logic              ldac_n,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_upd
);
    import dbl_dac_pkg::*;

    load_mode_e        mode;
    logic              par_open;
    logic              ser_en;
    logic              ser_done;
    logic [CODE_W-1:0] ser_code;
    logic [CODE_W-1:0] in_code;

    assign mode     = load_mode_e'(mode_ser);
    assign par_open = (mode == MODE_PAR) && !cs_n && !wr_n;
    assign ser_en   = (mode == MODE_SER);

    dbl_dac_serial_rx #(.CODE_W(CODE_W), .FRAME_W(FRAME_W)) i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_en     (ser_en),
        .sclk       (sclk),
        .sync_n     (sync_n),
        .sdata      (sdata),
        .frame_done (ser_done),
        .frame_code (ser_code)
    );

    dbl_dac_stage_reg #(.CODE_W(CODE_W)) i_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .par_open   (par_open),
        .par_data   (par_data),
        .ser_done   (ser_done),
        .ser_code   (ser_code),
        .stage_code (in_code)
    );

    dbl_dac_out_reg #(.CODE_W(CODE_W)) i_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .ldac_n     (ldac_n),
        .par_open   (par_open),
        .stage_code (in_code),
        .out_code   (dac_code),
        .out_upd    (dac_upd)
    );
endmodule

// File: rtl/dbl_dac_front_chk.sv
module dbl_dac_front_chk #(
    parameter int CODE_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_ser,
    input logic              cs_n,
    input logic              wr_n,
    input logic              ldac_n,
    input logic              ser_done,
    input logic [CODE_W-1:0] in_code,
    input logic [CODE_W-1:0] dac_code,
    input logic              dac_upd
);
    AST_INTERLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ser && !cs_n && !wr_n) |=> $stable(dac_code)); // R4

    AST_LDAC_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ldac_n |=> $stable(dac_code)); // R5

    AST_STAGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_ser && !ser_done) || (!mode_ser && (cs_n || wr_n))) |=> $stable(in_code)); // R9

    AST_UPD_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_upd |-> (dac_code != $past(dac_code))); // R10

    AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_upd |-> $stable(dac_code)); // R10

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_upd |=> !dac_upd || (dac_code != $past(dac_code))); // R10
endmodule

bind dbl_dac_front dbl_dac_front_chk #(.CODE_W(CODE_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_ser (mode_ser),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .ldac_n   (ldac_n),
    .ser_done (ser_done),
    .in_code  (in_code),
    .dac_code (dac_code),
    .dac_upd  (dac_upd)
);

// File: tb/test_dbl_dac_front.sv
module test_dbl_dac_front;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_ser = 1'b0;
    logic              cs_n = 1'b1;
    logic              wr_n = 1'b1;
    logic [CODE_W-1:0] par_data = '0;
    logic              sclk = 1'b1;
    logic              sync_n = 1'b1;
    logic              sdata = 1'b0;
    logic              ldac_n = 1'b1;
    logic [CODE_W-1:0] dac_code;
    logic              dac_upd;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbl_dac_front #(.CODE_W(CODE_W), .FRAME_W(16)) i_dbl_dac_front (
        .clk(clk), .rst_n(rst_n), .mode_ser(mode_ser), .cs_n(cs_n), .wr_n(wr_n),
        .par_data(par_data), .sclk(sclk), .sync_n(sync_n), .sdata(sdata),
        .ldac_n(ldac_n), .dac_code(dac_code), .dac_upd(dac_upd)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // each bit: sclk high two clocks, then low two clocks
    task automatic send_bits(input logic [15:0] word, input int nbits);
        for (int i = 15; i > 15 - nbits; i--) begin
            sdata = word[i];
            sclk  = 1'b1;
            tick(2);
            sclk  = 1'b0;
            tick(2);
        end
        sclk = 1'b1;
    endtask

    task automatic t_reset;
        tick(1);
        check("R1 code", dac_code, 0);
        check("R1 upd", dac_upd, 0);
        rst_n = 1'b1;
        tick(2);
        check("R1 code held", dac_code, 0);
    endtask

    task automatic t_ldac_held;
        ldac_n = 1'b1;
        mode_ser = 1'b0;
        cs_n = 1'b0; wr_n = 1'b0; par_data = 14'h0123;
        tick(1);
        par_data = 14'h1FFF;
        tick(1);
        wr_n = 1'b1;
        tick(3);
        check("R5 hold with ldac high", dac_code, 0);
        check("R10 no pulse", dac_upd, 0);
        cs_n = 1'b1;
        ldac_n = 1'b0;
        tick(1);
        check("R2 last value captured", dac_code, 14'h1FFF);
        check("R10 pulse", dac_upd, 1);
        ldac_n = 1'b1;
        tick(1);
        check("R10 pulse one cycle", dac_upd, 0);
    endtask

    task automatic t_interlock;
        ldac_n = 1'b0;
        tick(1);
        cs_n = 1'b0; wr_n = 1'b0; par_data = 14'h0555;
        tick(1);
        check("R4 held during write", dac_code, 14'h1FFF);
        par_data = 14'h2000;
        tick(1);
        check("R4 held during write late", dac_code, 14'h1FFF);
        check("R4 no pulse", dac_upd, 0);
        cs_n = 1'b1;
        tick(1);
        check("R6 auto update", dac_code, 14'h2000);
        check("R10 pulse on auto", dac_upd, 1);
        wr_n = 1'b1;
        tick(1);
        check("R10 pulse ends", dac_upd, 0);
    endtask

    task automatic t_strobe_ignore;
        cs_n = 1'b0; wr_n = 1'b1; par_data = 14'h0AAA;
        tick(3);
        check("R3 wr_n high", dac_code, 14'h2000);
        cs_n = 1'b1; wr_n = 1'b0; par_data = 14'h1555;
        tick(3);
        check("R3 cs_n high", dac_code, 14'h2000);
        wr_n = 1'b1;
        tick(1);
    endtask

    task automatic t_serial_in_par_mode;
        mode_ser = 1'b0;
        sync_n = 1'b0;
        send_bits(16'h0001, 16);
        tick(4);
        check("R9 serial ignored in par mode", dac_code, 14'h2000);
        sync_n = 1'b1;
        tick(1);
    endtask

    task automatic t_serial;
        mode_ser = 1'b1;
        cs_n = 1'b0; wr_n = 1'b0; par_data = 14'h0777;
        tick(3);
        check("R9 par ignored in serial mode", dac_code, 14'h2000);
        sync_n = 1'b0;
        tick(1);
        send_bits(16'hD234, 15);
        tick(4);
        check("R7 no update before 16th bit", dac_code, 14'h2000);
        sync_n = 1'b1;
        tick(2);
        sync_n = 1'b0;
        tick(1);
        send_bits(16'hD234, 16);
        tick(3);
        check("R7 frame code", dac_code, 14'h1234);
        sync_n = 1'b1;
        cs_n = 1'b1; wr_n = 1'b1;
        tick(2);
    endtask

    task automatic t_short_frame;
        sync_n = 1'b0;
        tick(1);
        send_bits(16'h0F0F, 10);
        sync_n = 1'b1;
        tick(6);
        check("R8 short frame discarded", dac_code, 14'h1234);
        sync_n = 1'b0;
        tick(1);
        send_bits(16'h3FFF, 16);
        tick(3);
        check("R8 next frame from bit 0", dac_code, 14'h3FFF);
        sync_n = 1'b1;
        tick(2);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        checks++;
        $display("FAIL R0 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_ldac_held();
        t_interlock();
        t_strobe_ignore();
        t_serial_in_par_mode();
        t_serial();
        t_short_frame();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule